// File: doc/BRIEF.md
# Per-Vector Interrupt Pending and In-Service Controller

This block is the local interrupt bookkeeping for a single processor. Every one of 256 interrupt vectors owns a pending flag and an in-service flag. Pending flags are raised by four kinds of source:

- single-cycle edge events naming a vector;
- level-sensitive lines, each mapped to a configurable vector;
- internal sources (timer, performance monitor, corrected error), each with its own configured vector;
- interrupt messages, which are taken only when their destination ID matches this processor.

Two further flags, for an initialization request and a performance-monitor request, stay set until an explicit clear pulse arrives. Neither of them has an in-service flag.

Software interacts through two strobes. An acquire read returns the highest deliverable pending vector and moves it from pending to in-service in the same cycle. An end-of-interrupt write retires the highest in-service vector. Priority rises with the vector number, and vectors form classes of 16 taken from their upper four bits. A pending vector is deliverable only when its class exceeds both a programmable mask class and the class of the highest in-service vector. A delivery request is raised when delivery is enabled and the top pending vector is deliverable.

Top module: `vec_intc`

## Requirements
- R1: A new event on a vector that is already pending is merged with it. A single acquire then retires the vector, and the next acquire finds nothing left from it.
- R2: A pending flag raised by an edge, internal or message source stays set until an acquire read takes that vector.
- R3: A level line marks its configured vector pending on every cycle its pin is high, so the vector is marked again right after an acquire. The flag is cleared on the clock edge after the pin goes low, even if the vector was never acquired. The vector of line i is `lvl_cfg[8i+7:8i]`.
- R4: An acquire read (`ack_rd` high) returns the top pending vector on `ack_vec` in the same cycle. At the next edge it clears that vector's pending flag and sets its in-service flag.
- R5: An `eoi_wr` pulse clears the in-service flag of the highest in-service vector and leaves the others set. With nothing in service it has no effect.
- R6: `init_set` and `pmi_set` set their own flags. The flags stay set until `init_clr` or `pmi_clr` is pulsed.
- R7: An acquire read with nothing deliverable returns vector 15 and changes no flag.
- R8: A message (`msg_vld`) marks `msg_vec` pending only when `msg_dest` equals `my_id`. There is no broadcast value.
- R9: A pulse on `int_evt[i]` marks the vector `int_cfg[8i+7:8i]` pending.
- R10: Only the highest pending vector can be delivered. It is deliverable only if its class (bits 7:4) is greater than `mask_class` and, when any vector is in service, greater than the class of the highest in-service vector.
- R11: `irq_out` is high exactly when `deliver_en` is high and the highest pending vector is deliverable.
- R12: When an acquire read and a new event on the acquired vector fall in the same cycle, the vector becomes in-service and also stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_id | input | 8 | Identifier of this processor |
| edge_vld | input | 1 | Edge event strobe |
| edge_vec | input | 8 | Vector of the edge event |
| lvl_pin | input | 4 | Level-sensitive lines |
| lvl_cfg | input | 32 | Vector per level line, 8 bits each |
| int_evt | input | 3 | Internal source event pulses |
| int_cfg | input | 24 | Vector per internal source, 8 bits each |
| msg_vld | input | 1 | Interrupt message strobe |
| msg_dest | input | 8 | Message destination ID |
| msg_vec | input | 8 | Message vector |
| init_set | input | 1 | Raise initialization request |
| init_clr | input | 1 | Clear initialization request |
| pmi_set | input | 1 | Raise performance-monitor request |
| pmi_clr | input | 1 | Clear performance-monitor request |
| mask_class | input | 4 | Classes at or below this value are masked |
| deliver_en | input | 1 | Delivery enable |
| ack_rd | input | 1 | Acquire read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| ack_vec | output | 8 | Acquire read data |
| irq_out | output | 1 | Delivery request |
| isr_vld | output | 1 | Some vector is in service |
| isr_vec | output | 8 | Highest in-service vector |
| init_pend | output | 1 | Initialization request pending |
| pmi_pend | output | 1 | Performance-monitor request pending |

## Verification
An acquire read and a fresh event on the very vector being acquired can land on the same clock edge. The first clears the pending flag, while the second must set it again. The bench provokes this by pulsing `edge_vld` with the top pending vector while `ack_rd` is high. It judges the result at the ports: the returned vector must be the one acquired, and `isr_vec` must show it in service. After an end-of-interrupt write, a second acquire must return the same vector again, proving the new occurrence was kept. The same-cycle acquire and end-of-interrupt pair is covered by an in-line property on the in-service flags.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  // Priority class of a vector: its upper bits.
  function automatic cls_t vec_class(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Deliverability rule: top pending class must beat mask and in-service class.
  function automatic logic may_deliver(logic pend_any, vec_t top, cls_t mask,
                                       logic isr_any, vec_t isr_top);
    logic ok;
    ok = pend_any && (vec_class(top) > mask);
    if (isr_any && (vec_class(top) <= vec_class(isr_top))) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/vintc_prio.sv
module vintc_prio #(
  parameter int W  = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vintc_src_decode.sv
module vintc_src_decode
  import vintc_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int NUM_INT = 3,
  parameter int ID_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     edge_vld,
  input  vec_t                     edge_vec,
  input  logic [NUM_LVL-1:0]       lvl_pin,
  input  logic [NUM_LVL*VEC_W-1:0] lvl_cfg,
  input  logic [NUM_INT-1:0]       int_evt,
  input  logic [NUM_INT*VEC_W-1:0] int_cfg,
  input  logic                     msg_vld,
  input  logic [ID_W-1:0]          msg_dest,
  input  vec_t                     msg_vec,
  input  logic [ID_W-1:0]          my_id,
  output logic [NUM_VEC-1:0]       set_mask,
  output logic [NUM_VEC-1:0]       fall_mask
);
  logic [NUM_LVL-1:0] lvl_prev;
  logic               msg_hit;

  assign msg_hit = msg_vld && (msg_dest == my_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl_pin;
  end

  always_comb begin
    set_mask  = '0;
    fall_mask = '0;
    if (edge_vld) set_mask[edge_vec] = 1'b1;
    if (msg_hit)  set_mask[msg_vec]  = 1'b1;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (lvl_pin[i])                  set_mask[lvl_cfg[i*VEC_W +: VEC_W]]  = 1'b1;
      if (lvl_prev[i] && !lvl_pin[i])  fall_mask[lvl_cfg[i*VEC_W +: VEC_W]] = 1'b1;
    end
    for (int j = 0; j < NUM_INT; j++) begin
      if (int_evt[j]) set_mask[int_cfg[j*VEC_W +: VEC_W]] = 1'b1;
    end
  end

  // R8: a message with a foreign destination raises nothing by itself
  a_r8_foreign_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && msg_dest != my_id && !edge_vld && lvl_pin == '0 && int_evt == '0)
      |-> set_mask == '0);
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vintc_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int NUM_INT  = 3,
  parameter int ID_W     = 8,
  parameter int SPUR_VEC = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          my_id,
  input  logic                     edge_vld,
  input  logic [VEC_W-1:0]         edge_vec,
  input  logic [NUM_LVL-1:0]       lvl_pin,
  input  logic [NUM_LVL*VEC_W-1:0] lvl_cfg,
  input  logic [NUM_INT-1:0]       int_evt,
  input  logic [NUM_INT*VEC_W-1:0] int_cfg,
  input  logic                     msg_vld,
  input  logic [ID_W-1:0]          msg_dest,
  input  logic [VEC_W-1:0]         msg_vec,
  input  logic                     init_set,
  input  logic                     init_clr,
  input  logic                     pmi_set,
  input  logic                     pmi_clr,
  input  logic [CLS_W-1:0]         mask_class,
  input  logic                     deliver_en,
  input  logic                     ack_rd,
  input  logic                     eoi_wr,
  output logic [VEC_W-1:0]         ack_vec,
  output logic                     irq_out,
  output logic                     isr_vld,
  output logic [VEC_W-1:0]         isr_vec,
  output logic                     init_pend,
  output logic                     pmi_pend
);
  localparam vec_t SPUR = VEC_W'(SPUR_VEC);

  logic [NUM_VEC-1:0] pend_q, isr_q;
  logic [NUM_VEC-1:0] set_mask, fall_mask;
  logic [NUM_VEC-1:0] ack_clr, eoi_clr;
  logic               pend_any, isr_any;
  vec_t               top_idx, isr_idx;
  logic               deliverable, ack_fire, eoi_fire;

  vintc_src_decode #(.NUM_LVL(NUM_LVL), .NUM_INT(NUM_INT), .ID_W(ID_W)) u_dec (
    .clk, .rst_n, .edge_vld, .edge_vec, .lvl_pin, .lvl_cfg, .int_evt, .int_cfg,
    .msg_vld, .msg_dest, .msg_vec, .my_id, .set_mask, .fall_mask
  );

  vintc_prio #(.W(NUM_VEC)) u_pend_enc (.req(pend_q), .any(pend_any), .idx(top_idx));
  vintc_prio #(.W(NUM_VEC)) u_isr_enc  (.req(isr_q),  .any(isr_any),  .idx(isr_idx));

  assign deliverable = may_deliver(pend_any, top_idx, mask_class, isr_any, isr_idx);
  assign ack_fire    = ack_rd && deliverable;
  assign eoi_fire    = eoi_wr && isr_any;

  always_comb begin
    ack_clr = '0;
    eoi_clr = '0;
    if (ack_fire) ack_clr[top_idx] = 1'b1;
    if (eoi_fire) eoi_clr[isr_idx] = 1'b1;
  end

  // New events win over the acquire clear and the level-fall clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      isr_q     <= '0;
      init_pend <= 1'b0;
      pmi_pend  <= 1'b0;
    end else begin
      pend_q    <= (pend_q & ~ack_clr & ~fall_mask) | set_mask;
      isr_q     <= (isr_q & ~eoi_clr) | ack_clr;
      init_pend <= (init_pend & ~init_clr) | init_set;
      pmi_pend  <= (pmi_pend & ~pmi_clr) | pmi_set;
    end
  end

  assign ack_vec = ack_fire ? top_idx : SPUR;
  assign irq_out = deliver_en && deliverable;
  assign isr_vld = isr_any;
  assign isr_vec = isr_idx;

  // R1 / R12: any raised vector is pending on the next cycle
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

  // R4: acquired vector becomes in-service
  a_r4_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(top_idx)]);

  // R4: acquired vector leaves pending unless re-raised
  a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !set_mask[top_idx]) |=> !pend_q[$past(top_idx)]);

  // R5: end-of-interrupt retires the top in-service vector
  a_r5_eoi_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && isr_any) |=> !isr_q[$past(isr_idx)]);

  // R3: a falling level line with no new event drops its vector
  a_r3_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_mask & ~set_mask) != '0) |=> ((pend_q & $past(fall_mask & ~set_mask)) == '0));

  // R7: a read with nothing deliverable and no other activity leaves flags alone
  a_r7_spur_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !deliverable && set_mask == '0 && fall_mask == '0 && !eoi_wr)
      |=> ($stable(pend_q) && $stable(isr_q)));

  // R10: an acquired vector outranks everything already in service
  a_r10_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && isr_any) |-> (vec_class(top_idx) > vec_class(isr_idx)));

  // R11: the delivery request needs enable and some pending vector
  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (deliver_en && pend_any));

  // R6: a clear pulse without set drops the request
  a_r6_init_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (init_clr && !init_set) |=> !init_pend);
endmodule

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  my_id = 8'd5;
  logic        edge_vld = 1'b0;
  logic [7:0]  edge_vec = '0;
  logic [3:0]  lvl_pin = '0;
  logic [31:0] lvl_cfg = {8'h00, 8'h00, 8'hC1, 8'hB0};
  logic [2:0]  int_evt = '0;
  logic [23:0] int_cfg = {8'hD7, 8'hD4, 8'hD2};
  logic        msg_vld = 1'b0;
  logic [7:0]  msg_dest = '0;
  logic [7:0]  msg_vec = '0;
  logic        init_set = 1'b0, init_clr = 1'b0, pmi_set = 1'b0, pmi_clr = 1'b0;
  logic [3:0]  mask_class = '0;
  logic        deliver_en = 1'b1;
  logic        ack_rd = 1'b0, eoi_wr = 1'b0;
  logic [7:0]  ack_vec, isr_vec;
  logic        irq_out, isr_vld, init_pend, pmi_pend;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  vec_intc u0 (.*);

  // {edge valid, edge vector, mask class, expected acquire result}
  localparam logic [20:0] TBL [10] = '{
    {1'b1, 8'h40, 4'd0,  8'h40},
    {1'b1, 8'h23, 4'd0,  8'h23},
    {1'b1, 8'h30, 4'd3,  8'h0F},
    {1'b0, 8'h00, 4'd2,  8'h30},
    {1'b1, 8'hFF, 4'd14, 8'hFF},
    {1'b1, 8'h81, 4'd8,  8'h0F},
    {1'b1, 8'h9A, 4'd8,  8'h9A},
    {1'b0, 8'h00, 4'd7,  8'h81},
    {1'b0, 8'h00, 4'd0,  8'h0F},
    {1'b1, 8'h10, 4'd0,  8'h10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_edge(input logic [7:0] v);
    edge_vld = 1'b1; edge_vec = v;
    @(negedge clk);
    edge_vld = 1'b0;
  endtask

  task automatic acquire(output logic [7:0] v);
    ack_rd = 1'b1;
    #1 v = ack_vec;
    @(negedge clk);
    ack_rd = 1'b0;
  endtask

  task automatic eoi();
    eoi_wr = 1'b1;
    @(negedge clk);
    eoi_wr = 1'b0;
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    #1;
    chk("R11 reset irq", irq_out, 0);
    chk("R5 reset isr", isr_vld, 0);
    chk("R6 reset init", init_pend, 0);
    @(negedge clk);
    acquire(got); chk("R7 reset read", got, 8'h0F);

    // Table walk: R4 / R10 / R7
    foreach (TBL[k]) begin
      mask_class = TBL[k][11:8];
      if (TBL[k][20]) pulse_edge(TBL[k][19:12]);
      acquire(got);
      chk("R10 table acquire", got, TBL[k][7:0]);
      if (TBL[k][7:0] != 8'h0F) begin
        #1 chk("R4 table in-service", isr_vec, TBL[k][7:0]);
        @(negedge clk);
        eoi();
      end
    end
    mask_class = '0;

    // R1: merged occurrences
    pulse_edge(8'h50); pulse_edge(8'h50);
    acquire(got); chk("R1 first read", got, 8'h50);
    eoi();
    acquire(got); chk("R1 merged gone", got, 8'h0F);

    // R2 + R11: persistence and delivery gate
    pulse_edge(8'h60);
    idle(10);
    #1 chk("R11 irq on", irq_out, 1);
    deliver_en = 1'b0;
    #1 chk("R11 irq gated", irq_out, 0);
    deliver_en = 1'b1;
    mask_class = 4'd6;
    #1 chk("R11 irq masked", irq_out, 0);
    mask_class = 4'd0;
    @(negedge clk);
    acquire(got); chk("R2 still pending", got, 8'h60);
    eoi();

    // R10 / R5: nesting and retirement order
    pulse_edge(8'h40);
    acquire(got); chk("R4 nest base", got, 8'h40);
    pulse_edge(8'h45);
    acquire(got); chk("R10 same class blocked", got, 8'h0F);
    #1 chk("R11 no irq same class", irq_out, 0);
    @(negedge clk);
    pulse_edge(8'h70);
    acquire(got); chk("R10 higher class", got, 8'h70);
    #1 chk("R4 isr top", isr_vec, 8'h70);
    @(negedge clk);
    eoi();
    #1 chk("R5 retire top only", isr_vec, 8'h40);
    chk("R5 still in service", isr_vld, 1);
    @(negedge clk);
    acquire(got); chk("R10 blocked by isr", got, 8'h0F);
    eoi();
    acquire(got); chk("R10 after retire", got, 8'h45);
    eoi();
    #1 chk("R5 all retired", isr_vld, 0);
    @(negedge clk);
    eoi();
    #1 chk("R5 empty eoi", isr_vld, 0);
    @(negedge clk);

    // R3: level lines
    lvl_pin[0] = 1'b1;
    @(negedge clk);
    acquire(got); chk("R3 level acquire", got, 8'hB0);
    eoi();
    acquire(got); chk("R3 level re-marked", got, 8'hB0);
    eoi();
    lvl_pin[0] = 1'b0;
    idle(2);
    acquire(got); chk("R3 level dropped", got, 8'h0F);
    lvl_pin[1] = 1'b1;
    idle(3);
    #1 chk("R3 level irq", irq_out, 1);
    @(negedge clk);
    lvl_pin[1] = 1'b0;
    idle(2);
    #1 chk("R3 unacquired drop irq", irq_out, 0);
    @(negedge clk);
    acquire(got); chk("R3 unacquired drop", got, 8'h0F);

    // R9: internal sources
    int_evt = 3'b001; @(negedge clk); int_evt = '0;
    acquire(got); chk("R9 source 0", got, 8'hD2);
    eoi();
    int_evt = 3'b100; @(negedge clk); int_evt = '0;
    acquire(got); chk("R9 source 2", got, 8'hD7);
    eoi();

    // R8: message destination
    msg_vld = 1'b1; msg_dest = 8'd6; msg_vec = 8'hE0;
    @(negedge clk); msg_vld = 1'b0;
    acquire(got); chk("R8 foreign dropped", got, 8'h0F);
    msg_vld = 1'b1; msg_dest = 8'd5;
    @(negedge clk); msg_vld = 1'b0;
    acquire(got); chk("R8 own accepted", got, 8'hE0);
    eoi();

    // R12: acquire and same-vector event in one cycle
    pulse_edge(8'h90);
    edge_vld = 1'b1; edge_vec = 8'h90;
    acquire(got);
    edge_vld = 1'b0;
    chk("R12 acquired", got, 8'h90);
    #1 chk("R12 in service", isr_vec, 8'h90);
    @(negedge clk);
    eoi();
    acquire(got); chk("R12 kept pending", got, 8'h90);
    eoi();
    acquire(got); chk("R12 then empty", got, 8'h0F);

    // R6: init / pmi flags
    init_set = 1'b1; pmi_set = 1'b1; @(negedge clk);
    init_set = 1'b0; pmi_set = 1'b0;
    idle(5);
    #1 chk("R6 init held", init_pend, 1);
    chk("R6 pmi held", pmi_pend, 1);
    @(negedge clk);
    init_clr = 1'b1; @(negedge clk); init_clr = 1'b0;
    #1 chk("R6 init cleared", init_pend, 0);
    chk("R6 pmi unaffected", pmi_pend, 1);
    @(negedge clk);
    pmi_clr = 1'b1; @(negedge clk); pmi_clr = 1'b0;
    #1 chk("R6 pmi cleared", pmi_pend, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule